// File: doc/BRIEF.md
# Integer to Half-Precision Converter

This block turns a 32-bit integer into an IEEE 754 binary16 value. One control bit selects whether the integer is read as two's-complement signed or as unsigned. The magnitude is normalised with a leading-zero count. It is then rounded to an 11-bit significand under the selected rounding direction and packed with its sign and biased exponent. Magnitudes past the binary16 range saturate either to infinity or to the largest finite value, depending on the rounding direction.

An operation is presented with a one-cycle `inValid` strobe. The rounding direction comes from a 3-bit field in which code 7 defers to a dynamic mode supplied from the status register. One clock edge later, `outValid` pulses together with three results:
- the 16-bit result, placed in the low half of a wider floating-point register word whose upper bits are all ones;
- the exception flags raised by this conversion;
- the caller's accrued flags, merged with the new ones.

Top module: `int2half_cvt`

## Requirements
- R1: With `srcSigned`=1 the source is read as two's complement. With `srcSigned`=0 it is read as unsigned. For example, 0xFFFFFFFF gives 0xBC00 (-1.0) when signed and overflows when unsigned.
- R2: An exactly representable magnitude m, with 2^p <= m < 2^(p+1), is encoded as {sign, p+15 in bits 14:10, the fraction bits below the leading one in bits 9:0}. It raises no flag.
- R3: Round-to-nearest-even (code 0) chooses the nearer neighbour. On an exact tie it chooses the neighbour whose significand is even.
- R4: Code 1 truncates toward zero. Code 2 rounds toward minus infinity. Code 3 rounds toward plus infinity. Code 4 rounds to nearest with ties going away from zero. Any discarded nonzero bits raise inexact, which is flag bit 0.
- R5: Rounding-field code 7 applies the mode given on `dynRm`. Any other code ignores `dynRm`.
- R6: A zero source, signed or unsigned, gives +0 (0x0000) with no flag, in every mode.
- R7: If the rounded magnitude reaches 65536, overflow (flag bit 2) and inexact (flag bit 0) are raised. Under codes 0 and 4 the result is the signed infinity 0x7C00/0xFC00. This happens for every magnitude of 65520 or more.
- R8: On overflow under code 1, under code 2 with a positive source, or under code 3 with a negative source, the result is the signed largest finite value 0x7BFF/0xFBFF.
- R9: Bits FLEN-1:16 of `resultFp` are all ones on every result.
- R10: `accruedOut` equals `accruedIn` (sampled with the operation) OR'ed with `opFlags`. Flag bits 1, 3 and 4 are never raised.
- R11: `outValid` is high exactly one cycle after each `inValid` cycle and low otherwise.
- R12: A resolved mode of 5, 6 or 7, whether coded directly or obtained through `dynRm`, rounds as code 0.
- R13: After reset `outValid` is 0, `opFlags` and `accruedOut` are 0, and the low 16 bits of `resultFp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| srcInt | input | INT_W | Integer source |
| srcSigned | input | 1 | 1: two's-complement source, 0: unsigned |
| rmField | input | 3 | Rounding code from the operation; 7 selects `dynRm` |
| dynRm | input | 3 | Dynamic rounding mode from the status register |
| accruedIn | input | 5 | Accrued flags before this operation |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| resultFp | output | FLEN | NaN-boxed binary16 result |
| opFlags | output | 5 | Flags from this conversion (bit 2 overflow, bit 0 inexact) |
| accruedOut | output | 5 | `accruedIn` merged with `opFlags` |

## Verification
All integers from 0 to 4095 are swept. This range separates exact encodings below 2048 from the first rounding steps above it, where ties alternate between even and odd significands. A dense window around 65504 to 65600 is swept in all five modes with both signs. That window pins the overflow threshold and the infinity versus largest-finite choice for each direction. Walking-one, one-plus-one and all-ones-below patterns at every bit position exercise the leading-zero count and the sticky bit across the full 32-bit range. Directed cases cover the signed and unsigned reading of the same bit patterns, dynamic and out-of-range rounding codes, zero, and the merging of accrued flags.

// File: rtl/i2h_pkg.sv
package i2h_pkg;

  typedef enum logic [2:0] {
    RM_RNE = 3'd0,
    RM_RTZ = 3'd1,
    RM_RDN = 3'd2,
    RM_RUP = 3'd3,
    RM_RMM = 3'd4
  } rndMode_e;

  localparam logic [2:0] RM_DYN = 3'd7;

  localparam int FLAG_W  = 5;
  localparam int FLAG_NX = 0;
  localparam int FLAG_OF = 2;

  localparam int HALF_W    = 16;
  localparam int HALF_MANT = 10;
  localparam int HALF_EXP  = 5;
  localparam int HALF_BIAS = 15;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     load;
    rndMode_e mode;
  } cvtStrobe_t;

endpackage

// File: rtl/i2h_ctrl.sv
module i2h_ctrl
  import i2h_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] rmField,
  input  logic [2:0] dynRm,
  output cvtStrobe_t strobe,
  output logic       outValid
);

  logic [2:0] rawMode;

  // Code 7 defers to the status register; codes past 4 fall back to RNE.
  always_comb begin
    rawMode = (rmField == RM_DYN) ? dynRm : rmField;
    strobe.load = inValid;
    if (rawMode <= 3'd4) strobe.mode = rndMode_e'(rawMode);
    else                 strobe.mode = RM_RNE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/i2h_dpath.sv
module i2h_dpath
  import i2h_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int FLEN  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  cvtStrobe_t        strobe,
  input  logic [INT_W-1:0]  srcInt,
  input  logic              srcSigned,
  input  logic [FLAG_W-1:0] accruedIn,
  output logic [FLEN-1:0]   resultFp,
  output logic [FLAG_W-1:0] opFlags,
  output logic [FLAG_W-1:0] accruedOut
);

  localparam int LZ_W    = $clog2(INT_W + 1);
  localparam int EXP_W   = $clog2(INT_W + HALF_BIAS) + 1;
  localparam int SIG_W   = HALF_MANT + 1;
  localparam int BOX_W   = FLEN - HALF_W;
  localparam int EXP_MAX = (1 << HALF_EXP) - 1;

  logic                 negIn, isZero;
  logic [INT_W-1:0]     mag, norm;
  logic [LZ_W-1:0]      lzCnt;
  logic [SIG_W-1:0]     sigTop;
  logic                 guardBit, stickyBit, inexact, roundUp, carry, toInf, overflow;
  logic [HALF_MANT-1:0] mantOut;
  logic [EXP_W-1:0]     expBiased;
  logic [HALF_W-1:0]    halfD, halfQ;
  logic [FLAG_W-1:0]    flagsD, flagsQ, accQ;

  // Sign and magnitude.
  always_comb begin
    negIn  = srcSigned & srcInt[INT_W-1];
    mag    = negIn ? (~srcInt + INT_W'(1)) : srcInt;
    isZero = (mag == '0);
  end

  // Leading-zero count: the highest set bit wins.
  always_comb begin
    lzCnt = LZ_W'(INT_W);
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lzCnt = LZ_W'(INT_W - 1 - i);
    end
  end

  // Normalise, then split into significand, guard and sticky.
  always_comb begin
    norm      = mag << lzCnt;
    sigTop    = norm[INT_W-1 -: SIG_W];
    guardBit  = norm[INT_W-SIG_W-1];
    stickyBit = |norm[INT_W-SIG_W-2:0];
    inexact   = guardBit | stickyBit;
  end

  // Round-increment decision and overflow target per mode.
  always_comb begin
    unique case (strobe.mode)
      RM_RTZ:  roundUp = 1'b0;
      RM_RDN:  roundUp = negIn & inexact;
      RM_RUP:  roundUp = ~negIn & inexact;
      RM_RMM:  roundUp = guardBit;
      default: roundUp = guardBit & (stickyBit | sigTop[0]);
    endcase
    unique case (strobe.mode)
      RM_RTZ:  toInf = 1'b0;
      RM_RDN:  toInf = negIn;
      RM_RUP:  toInf = ~negIn;
      default: toInf = 1'b1;
    endcase
  end

  // Apply the increment; a carry out bumps the exponent and clears the fraction.
  always_comb begin
    carry     = roundUp & (&sigTop);
    mantOut   = sigTop[HALF_MANT-1:0] + HALF_MANT'(roundUp);
    expBiased = EXP_W'(INT_W - 1) - EXP_W'(lzCnt) + EXP_W'(HALF_BIAS) + EXP_W'(carry);
    overflow  = !isZero && (expBiased >= EXP_W'(EXP_MAX));
  end

  // Pack the result and flags.
  always_comb begin
    halfD  = '0;
    flagsD = '0;
    if (isZero) begin
      halfD = '0;
    end else if (overflow) begin
      halfD = toInf ? {negIn, {HALF_EXP{1'b1}}, {HALF_MANT{1'b0}}}
                    : {negIn, HALF_EXP'(EXP_MAX - 1), {HALF_MANT{1'b1}}};
      flagsD[FLAG_OF] = 1'b1;
      flagsD[FLAG_NX] = 1'b1;
    end else begin
      halfD = {negIn, expBiased[HALF_EXP-1:0], mantOut};
      flagsD[FLAG_NX] = inexact;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ  <= '0;
      flagsQ <= '0;
      accQ   <= '0;
    end else if (strobe.load) begin
      halfQ  <= halfD;
      flagsQ <= flagsD;
      accQ   <= accruedIn | flagsD;
    end
  end

  generate
    if (BOX_W > 0) begin : g_box
      assign resultFp = {{BOX_W{1'b1}}, halfQ};
    end else begin : g_nobox
      assign resultFp = halfQ;
    end
  endgenerate

  assign opFlags    = flagsQ;
  assign accruedOut = accQ;

endmodule

// File: rtl/int2half_cvt.sv
module int2half_cvt
  import i2h_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int FLEN  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [INT_W-1:0]  srcInt,
  input  logic              srcSigned,
  input  logic [2:0]        rmField,
  input  logic [2:0]        dynRm,
  input  logic [FLAG_W-1:0] accruedIn,
  output logic              outValid,
  output logic [FLEN-1:0]   resultFp,
  output logic [FLAG_W-1:0] opFlags,
  output logic [FLAG_W-1:0] accruedOut
);

  cvtStrobe_t strobe;

  i2h_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rmField  (rmField),
    .dynRm    (dynRm),
    .strobe   (strobe),
    .outValid (outValid)
  );

  i2h_dpath #(.INT_W(INT_W), .FLEN(FLEN)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcInt     (srcInt),
    .srcSigned  (srcSigned),
    .accruedIn  (accruedIn),
    .resultFp   (resultFp),
    .opFlags    (opFlags),
    .accruedOut (accruedOut)
  );

endmodule

// File: rtl/i2h_checker.sv
module i2h_checker #(
  parameter int INT_W = 32,
  parameter int FLEN  = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [INT_W-1:0] srcInt,
  input logic [4:0]       accruedIn,
  input logic             outValid,
  input logic [FLEN-1:0]  resultFp,
  input logic [4:0]       opFlags,
  input logic [4:0]       accruedOut
);

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R11
  AST_NAN_BOX: assert property (@(posedge clk) disable iff (!rstN) outValid |-> (&resultFp[FLEN-1:16])); // R9
  AST_ACCRUE_KEEP: assert property (@(posedge clk) disable iff (!rstN) outValid |-> ((accruedOut & $past(accruedIn)) == $past(accruedIn))); // R10
  AST_ACCRUE_NEW: assert property (@(posedge clk) disable iff (!rstN) outValid |-> ((accruedOut & opFlags) == opFlags)); // R10
  AST_UNUSED_FLAGS: assert property (@(posedge clk) disable iff (!rstN) outValid |-> (opFlags[4] == 1'b0 && opFlags[3] == 1'b0 && opFlags[1] == 1'b0)); // R10
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rstN) (inValid && srcInt == '0) |=> (resultFp[15:0] == 16'h0 && opFlags == 5'h0)); // R6
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rstN) (outValid && opFlags[2]) |-> opFlags[0]); // R7
  AST_FINITE_EXP: assert property (@(posedge clk) disable iff (!rstN) (outValid && !opFlags[2]) |-> (resultFp[14:10] != 5'h1F)); // R2

endmodule

bind int2half_cvt i2h_checker #(.INT_W(INT_W), .FLEN(FLEN)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .srcInt     (srcInt),
  .accruedIn  (accruedIn),
  .outValid   (outValid),
  .resultFp   (resultFp),
  .opFlags    (opFlags),
  .accruedOut (accruedOut)
);

// File: tb/int2half_cvt_tb_top.sv
module int2half_cvt_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FLEN = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcInt = '0;
  logic        srcSigned = 1'b0;
  logic [2:0]  rmField = '0;
  logic [2:0]  dynRm = '0;
  logic [4:0]  accruedIn = '0;
  logic        outValid;
  logic [FLEN-1:0] resultFp;
  logic [4:0]  opFlags;
  logic [4:0]  accruedOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int2half_cvt #(.INT_W(32), .FLEN(FLEN)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcInt(srcInt),
    .srcSigned(srcSigned), .rmField(rmField), .dynRm(dynRm),
    .accruedIn(accruedIn), .outValid(outValid), .resultFp(resultFp),
    .opFlags(opFlags), .accruedOut(accruedOut)
  );

  // Arithmetic reference: bracket the magnitude between the two neighbouring
  // representable values and pick one by the rounding direction.
  function automatic void refConv(input logic [31:0] x, input logic sgn, input int mode,
                                  output logic [15:0] h, output logic [4:0] fl);
    longint sx, m, q, lo, hi, r, pick;
    int p, pc;
    bit neg, toInf;
    logic [15:0] mant;
    sx  = sgn ? longint'($signed(x)) : longint'({32'h0, x});
    neg = (sx < 0);
    m   = neg ? -sx : sx;
    h = 16'h0; fl = 5'h0;
    if (m == 0) return;
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    q  = (p <= 10) ? 1 : (longint'(1) << (p - 10));
    lo = (m / q) * q;
    r  = m - lo;
    hi = lo + q;
    if (r == 0) pick = lo;
    else begin
      case (mode)
        1: pick = lo;
        2: pick = neg ? hi : lo;
        3: pick = neg ? lo : hi;
        4: pick = (2 * r >= q) ? hi : lo;
        default: pick = (2 * r < q) ? lo : (2 * r > q) ? hi : (((lo / q) % 2) == 0 ? lo : hi);
      endcase
    end
    if (pick > 65504) begin
      toInf = (mode == 0) || (mode == 4) || (mode == 3 && !neg) || (mode == 2 && neg);
      h  = {neg, toInf ? 15'h7C00 : 15'h7BFF};
      fl = 5'b00101;
      return;
    end
    pc = 0;
    while ((pick >> (pc + 1)) != 0) pc++;
    mant = (pc >= 10) ? 16'(pick >> (pc - 10)) : 16'(pick << (10 - pc));
    h  = {neg, 5'(pc + 15), mant[9:0]};
    fl = (r != 0) ? 5'b00001 : 5'b00000;
  endfunction

  // Drives one operation and checks the result one clock edge later.
  task automatic runOp(input logic [31:0] x, input logic sgn, input logic [2:0] rmf,
                       input logic [2:0] dyn, input logic [4:0] acc, input string tag);
    logic [15:0] eh;
    logic [4:0]  ef;
    int mode;
    mode = (rmf == 3'd7) ? int'(dyn) : int'(rmf);
    if (mode > 4) mode = 0;
    refConv(x, sgn, mode, eh, ef);
    srcInt = x; srcSigned = sgn; rmField = rmf; dynRm = dyn; accruedIn = acc;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compared++;
    if (outValid !== 1'b1 || resultFp !== {{(FLEN-16){1'b1}}, eh} ||
        opFlags !== ef || accruedOut !== (acc | ef)) begin
      mismatched++;
      $display("FAIL %s x=%h s=%0b rm=%0d dyn=%0d: got v=%b res=%h fl=%h acc=%h, expected v=1 res=%h fl=%h acc=%h",
               tag, x, sgn, rmf, dyn, outValid, resultFp, opFlags, accruedOut,
               {{(FLEN-16){1'b1}}, eh}, ef, acc | ef);
    end
    inValid = 1'b0;
  endtask

  task automatic checkBit(input bit ok, input string tag, input string what);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    checkBit(outValid === 1'b0 && opFlags === 5'h0 && accruedOut === 5'h0 && resultFp[15:0] === 16'h0,
             "R13", $sformatf("got v=%b fl=%h acc=%h res=%h, expected 0/0/0/0", outValid, opFlags, accruedOut, resultFp[15:0]));
    rstN = 1'b1;
    @(negedge clk);

    // R6 zero in every mode, both readings
    for (int m = 0; m < 5; m++) begin
      runOp(32'h0, 1'b1, 3'(m), 3'd0, 5'h0, "R6");
      runOp(32'h0, 1'b0, 3'(m), 3'd0, 5'h0, "R6");
    end

    // R2/R3 exhaustive small range (exact below 2048, ties above), R9 boxing on every result
    for (int v = 0; v < 4096; v++) runOp(32'(v), 1'b0, 3'd0, 3'd0, 5'h0, "R2_R3_R9");

    // R3 explicit ties: 2049 -> 2048 (0x6800), 2051 -> 2052 (0x6802)
    runOp(32'd2049, 1'b0, 3'd0, 3'd0, 5'h0, "R3");
    runOp(32'd2051, 1'b0, 3'd0, 3'd0, 5'h0, "R3");

    // R4 R7 R8 overflow window, every mode, both signs
    for (int v = 65400; v <= 65600; v++)
      for (int m = 0; m < 5; m++) begin
        runOp(32'(v), 1'b1, 3'(m), 3'd0, 5'h0, "R4_R7_R8");
        runOp(32'(-v), 1'b1, 3'(m), 3'd0, 5'h0, "R4_R7_R8");
      end

    // R4 walking patterns across all bit positions
    for (int sh = 0; sh < 32; sh++)
      for (int m = 0; m < 5; m++) begin
        runOp(32'h1 << sh, 1'b0, 3'(m), 3'd0, 5'h0, "R4");
        runOp((32'h1 << sh) | 32'h1, 1'b0, 3'(m), 3'd0, 5'h0, "R4");
        runOp((32'h1 << sh) - 32'h1, 1'b0, 3'(m), 3'd0, 5'h0, "R4");
        runOp(32'h1 << sh, 1'b1, 3'(m), 3'd0, 5'h0, "R4");
        runOp((32'h1 << sh) | 32'h5, 1'b1, 3'(m), 3'd0, 5'h0, "R4");
      end

    // R1 signed versus unsigned reading
    runOp(32'hFFFFFFFF, 1'b1, 3'd0, 3'd0, 5'h0, "R1");
    runOp(32'hFFFFFFFF, 1'b0, 3'd0, 3'd0, 5'h0, "R1");
    runOp(32'h80000000, 1'b1, 3'd1, 3'd0, 5'h0, "R1");
    runOp(32'h80000000, 1'b0, 3'd1, 3'd0, 5'h0, "R1");
    runOp(32'hFFFFF000, 1'b1, 3'd2, 3'd0, 5'h0, "R1");

    // R7 R8 extremes
    runOp(32'h7FFFFFFF, 1'b1, 3'd0, 3'd0, 5'h0, "R7");
    runOp(32'h7FFFFFFF, 1'b1, 3'd1, 3'd0, 5'h0, "R8");
    runOp(32'h80000001, 1'b1, 3'd3, 3'd0, 5'h0, "R8");

    // R5 dynamic mode and ignoring of dynRm otherwise
    for (int d = 0; d < 5; d++) begin
      runOp(32'd65519, 1'b1, 3'd7, 3'(d), 5'h0, "R5");
      runOp(32'hFFFF0011, 1'b1, 3'd7, 3'(d), 5'h0, "R5");
      runOp(32'd2051, 1'b0, 3'd1, 3'(d), 5'h0, "R5");
    end

    // R12 out-of-range codes fall back to nearest-even
    runOp(32'd2051, 1'b0, 3'd5, 3'd1, 5'h0, "R12");
    runOp(32'd2051, 1'b0, 3'd6, 3'd1, 5'h0, "R12");
    runOp(32'd65520, 1'b0, 3'd7, 3'd5, 5'h0, "R12");
    runOp(32'd65520, 1'b0, 3'd7, 3'd6, 5'h0, "R12");
    runOp(32'd2049, 1'b0, 3'd7, 3'd7, 5'h0, "R12");

    // R10 accrued merge
    runOp(32'd2049, 1'b0, 3'd0, 3'd0, 5'h1A, "R10");
    runOp(32'd70000, 1'b0, 3'd0, 3'd0, 5'h10, "R10");
    runOp(32'd1000, 1'b0, 3'd0, 3'd0, 5'h1F, "R10");
    runOp(32'd0, 1'b1, 3'd0, 3'd0, 5'h0A, "R10");

    // R11 no result strobe without an operation
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkBit(outValid === 1'b0, "R11", $sformatf("got outValid=%b, expected 0", outValid));
    @(posedge clk);
    @(negedge clk);
    checkBit(outValid === 1'b0, "R11", $sformatf("got outValid=%b, expected 0", outValid));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule